// File: doc/BRIEF.md
# Vectorizing Register Remap Unit

This block sits between instruction decode and the register files. Each operand carries a 5-bit architectural register number and a bit that says whether it names an integer or a floating-point register. The block looks that number up in a 32-entry redirection table for the chosen class and returns a 6-bit physical register number. Both physical register files hold 64 entries.

A table entry that is not active leaves the register number unchanged, zero-extended to 6 bits. An active entry replaces the number with its stored 6-bit target. If the entry is also marked as a vector, the current element offset of the vector loop is added to the target. This lets a vector instruction walk through contiguous registers. An entry can also be active without being a vector. That form redirects a scalar operand, so a 5-bit field can reach any of the 64 physical registers.

The block reports whether any operand in use was redirected. Together with the vector length, that decides whether the element loop goes on. Software fills the tables through a synchronous write port. The lookups are combinational.

Top module: `vec_remap_unit`

## Requirements
- R1: After reset every entry in both tables is inactive. Each lookup then returns its input number with a zero sixth bit, and `lk_hit` is all zeros.
- R2: `wr_fp`=0 writes the integer table and `wr_fp`=1 writes the floating-point table. A write to one table has no effect on a lookup of the same index in the other table (`lk_fp` has the same encoding).
- R3: When the selected entry is inactive, the port's `phys_reg` field equals {1'b0, arch}, whatever the element offset is.
- R4: When the selected entry is active and not a vector, `phys_reg` equals the stored target, and the element offset is ignored.
- R5: When the selected entry is active and is a vector, `phys_reg` equals (target + `elem_offs`) mod 64.
- R6: `loop_continue` is 1 exactly when at least one port with its `lk_use` bit set hits an active entry. Hits on ports whose `lk_use` bit is clear are ignored.
- R7: `loop_stop` is 1 when `vec_len` is zero or `loop_continue` is 0, and 0 otherwise.
- R8: A write changes lookups from the clock edge that accepts it onward. A lookup in the same cycle as a write still sees the old entry.
- R9: `lk_hit[i]` reports that port i's entry is active. `lk_vec[i]` reports that it is active and a vector.
- R10: Port i occupies bits [5i+4:5i] of `lk_reg` and bits [6i+5:6i] of `phys_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Table write strobe |
| wr_fp | input | 1 | Write target table: 0 integer, 1 floating-point |
| wr_idx | input | 5 | Entry index to write |
| wr_active | input | 1 | Active flag to store |
| wr_isvec | input | 1 | Vector flag to store |
| wr_target | input | 6 | Target physical register to store |
| lk_use | input | NPORT | Operand in use, one bit per port |
| lk_fp | input | NPORT | Table select per port (1 = floating-point) |
| lk_reg | input | 5*NPORT | Architectural register per port |
| elem_offs | input | 6 | Current element offset of the loop |
| vec_len | input | VLW | Current vector length |
| phys_reg | output | 6*NPORT | Physical register per port |
| lk_hit | output | NPORT | Entry active, per port |
| lk_vec | output | NPORT | Entry active and vector, per port |
| loop_continue | output | 1 | An operand in use was redirected |
| loop_stop | output | 1 | The element loop must end |

## Verification
All lookup outputs are combinational. The bench drives operands on the falling edge and compares one time unit later, in the same half cycle and before any edge. A write driven in that same half cycle is committed at the next rising edge. The reference tables are updated only after that edge, so the compare against the old contents checks the read-before-write order. After reset is released, the internal synchronizer holds the tables in reset for two more rising edges. No write is issued until that window has passed.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
  localparam int ARCH_W = 5;
  localparam int PHYS_W = 6;
  localparam int NENT   = 1 << ARCH_W;

  typedef struct packed {
    logic              active;
    logic              isvec;
    logic [PHYS_W-1:0] target;
  } map_ent_t;
endpackage

// File: rtl/vrm_rst_sync.sv
module vrm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/vrm_table.sv
module vrm_table
  import vrm_pkg::*;
#(
  parameter int NRD = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [ARCH_W-1:0]            wr_idx,
  input  map_ent_t                     wr_ent,
  input  logic [NRD-1:0][ARCH_W-1:0]   rd_idx,
  output map_ent_t [NRD-1:0]           rd_ent
);
  logic [NENT-1:0]             act_q, act_d;
  logic [NENT-1:0]             vec_q, vec_d;
  logic [NENT-1:0][PHYS_W-1:0] tgt_q, tgt_d;

  // next-state
  always_comb begin
    act_d = act_q;
    vec_d = vec_q;
    tgt_d = tgt_q;
    if (wr_en) begin
      act_d[wr_idx] = wr_ent.active;
      vec_d[wr_idx] = wr_ent.isvec;
      tgt_d[wr_idx] = wr_ent.target;
    end
  end

  // active flags carry reset; payload fields are only clock-enabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     act_q <= '0;
    else if (wr_en) act_q <= act_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      vec_q <= vec_d;
      tgt_q <= tgt_d;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    always_comb begin
      rd_ent[p].active = act_q[rd_idx[p]];
      rd_ent[p].isvec  = vec_q[rd_idx[p]];
      rd_ent[p].target = tgt_q[rd_idx[p]];
    end
  end
endmodule

// File: rtl/vrm_resolve.sv
module vrm_resolve
  import vrm_pkg::*;
(
  input  logic [ARCH_W-1:0] arch,
  input  map_ent_t          ent,
  input  logic [PHYS_W-1:0] offs,
  output logic [PHYS_W-1:0] phys,
  output logic              hit,
  output logic              vec
);
  logic [PHYS_W-1:0] sum;

  always_comb begin
    sum = ent.target + offs;
    hit = ent.active;
    vec = ent.active & ent.isvec;
    if (!ent.active)    phys = {{(PHYS_W-ARCH_W){1'b0}}, arch};
    else if (ent.isvec) phys = sum;
    else                phys = ent.target;
  end
endmodule

// File: rtl/vec_remap_unit.sv
module vec_remap_unit #(
  parameter int NPORT = 3,
  parameter int VLW   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_fp,
  input  logic [4:0]         wr_idx,
  input  logic               wr_active,
  input  logic               wr_isvec,
  input  logic [5:0]         wr_target,
  input  logic [NPORT-1:0]   lk_use,
  input  logic [NPORT-1:0]   lk_fp,
  input  logic [5*NPORT-1:0] lk_reg,
  input  logic [5:0]         elem_offs,
  input  logic [VLW-1:0]     vec_len,
  output logic [6*NPORT-1:0] phys_reg,
  output logic [NPORT-1:0]   lk_hit,
  output logic [NPORT-1:0]   lk_vec,
  output logic               loop_continue,
  output logic               loop_stop
);
  import vrm_pkg::*;
  localparam int NTAB = 2;

  logic                           rst_n_int;
  map_ent_t                       wr_ent;
  logic [NPORT-1:0][ARCH_W-1:0]   arch_v;
  map_ent_t [NTAB-1:0][NPORT-1:0] tab_ent;
  map_ent_t [NPORT-1:0]           sel_ent;

  vrm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int));

  assign wr_ent = '{active: wr_active, isvec: wr_isvec, target: wr_target};

  for (genvar p = 0; p < NPORT; p++) begin : g_unpack
    assign arch_v[p] = lk_reg[p*ARCH_W +: ARCH_W];
  end

  // table 0 = integer, table 1 = floating-point
  for (genvar t = 0; t < NTAB; t++) begin : g_tab
    logic tab_we;
    assign tab_we = wr_en & (wr_fp == 1'(t));
    vrm_table #(.NRD(NPORT)) u_tab (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .wr_en  (tab_we),
      .wr_idx (wr_idx),
      .wr_ent (wr_ent),
      .rd_idx (arch_v),
      .rd_ent (tab_ent[t])
    );
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign sel_ent[p] = lk_fp[p] ? tab_ent[1][p] : tab_ent[0][p];
    vrm_resolve u_res (
      .arch (arch_v[p]),
      .ent  (sel_ent[p]),
      .offs (elem_offs),
      .phys (phys_reg[p*PHYS_W +: PHYS_W]),
      .hit  (lk_hit[p]),
      .vec  (lk_vec[p])
    );
  end

  assign loop_continue = |(lk_hit & lk_use);
  assign loop_stop     = (vec_len == '0) | ~loop_continue;
endmodule

// File: rtl/vrm_checker.sv
module vrm_checker #(
  parameter int NPORT = 3,
  parameter int VLW   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NPORT-1:0]   lk_use,
  input logic [5*NPORT-1:0] lk_reg,
  input logic [VLW-1:0]     vec_len,
  input logic [6*NPORT-1:0] phys_reg,
  input logic [NPORT-1:0]   lk_hit,
  input logic [NPORT-1:0]   lk_vec,
  input logic               loop_continue,
  input logic               loop_stop
);
  a_r1_clear_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (lk_hit == '0));

  a_r9_vec_implies_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_vec & ~lk_hit) == '0);

  a_r7_zero_len_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_len == '0) |-> loop_stop);

  a_r7_runs_when_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_continue && vec_len != '0) |-> !loop_stop);

  a_r6_no_hit_no_continue: assert property (@(posedge clk) disable iff (!rst_n)
    ((lk_hit & lk_use) == '0) |-> !loop_continue);

  for (genvar p = 0; p < NPORT; p++) begin : g_pass
    a_r3_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit[p] |-> (phys_reg[p*6 +: 6] == {1'b0, lk_reg[p*5 +: 5]}));
  end
endmodule

bind vec_remap_unit vrm_checker #(.NPORT(NPORT), .VLW(VLW)) u_chk (.*);

// File: tb/vec_remap_unit_tb.sv
module vec_remap_unit_tb;
  localparam int NPORT = 3;
  localparam int VLW   = 7;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               wr_en = 1'b0, wr_fp = 1'b0, wr_active = 1'b0, wr_isvec = 1'b0;
  logic [4:0]         wr_idx = '0;
  logic [5:0]         wr_target = '0;
  logic [NPORT-1:0]   lk_use = '0, lk_fp = '0;
  logic [5*NPORT-1:0] lk_reg = '0;
  logic [5:0]         elem_offs = '0;
  logic [VLW-1:0]     vec_len = '0;
  logic [6*NPORT-1:0] phys_reg;
  logic [NPORT-1:0]   lk_hit, lk_vec;
  logic               loop_continue, loop_stop;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  // reference tables, index [table][entry]
  bit       m_act [2][32];
  bit       m_vec [2][32];
  bit [5:0] m_tgt [2][32];

  always #4 clk = ~clk;

  vec_remap_unit #(.NPORT(NPORT), .VLW(VLW)) u_dut (.*);

  function automatic bit [5:0] exp_phys(bit fp, bit [4:0] r, bit [5:0] o);
    if (!m_act[fp][r]) return {1'b0, r};
    if (m_vec[fp][r])  return 6'(m_tgt[fp][r] + o);
    return m_tgt[fp][r];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_all(string ctx);
    bit cont = 0;
    for (int p = 0; p < NPORT; p++) begin
      bit fp = lk_fp[p];
      bit [4:0] r = lk_reg[p*5 +: 5];
      string rq = !m_act[fp][r] ? "R3" : (m_vec[fp][r] ? "R5" : "R4");
      chk({rq, "/R10 phys ", ctx}, 32'(phys_reg[p*6 +: 6]), 32'(exp_phys(fp, r, elem_offs)));
      chk({"R9 hit ", ctx}, 32'(lk_hit[p]), 32'(m_act[fp][r]));
      chk({"R9 vec ", ctx}, 32'(lk_vec[p]), 32'(m_act[fp][r] & m_vec[fp][r]));
      if (lk_use[p] && m_act[fp][r]) cont = 1;
    end
    chk({"R6 continue ", ctx}, 32'(loop_continue), 32'(cont));
    chk({"R7 stop ", ctx}, 32'(loop_stop), 32'((vec_len == 0) || !cont));
  endtask

  // drive write at negedge; model updated after the committing edge
  task automatic do_write(bit fp, bit [4:0] idx, bit a, bit v, bit [5:0] t);
    @(negedge clk);
    wr_en = 1; wr_fp = fp; wr_idx = idx; wr_active = a; wr_isvec = v; wr_target = t;
    @(posedge clk); #1;
    wr_en = 0;
    m_act[fp][idx] = a; m_vec[fp][idx] = v; m_tgt[fp][idx] = t;
  endtask

  task automatic look(bit [NPORT-1:0] u, bit [NPORT-1:0] f, bit [4:0] r0, bit [4:0] r1,
                      bit [4:0] r2, bit [5:0] o, bit [VLW-1:0] vl, string ctx);
    @(negedge clk);
    lk_use = u; lk_fp = f; lk_reg = {r2, r1, r0}; elem_offs = o; vec_len = vl;
    #1 check_all(ctx);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int t = 0; t < 2; t++)
      for (int i = 0; i < 32; i++) begin m_act[t][i] = 0; m_vec[t][i] = 0; m_tgt[t][i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1: reset state, all lookups pass through
    look(3'b111, 3'b010, 5'd31, 5'd7, 5'd0, 6'd13, 7'd4, "R1 reset");
    look(3'b111, 3'b101, 5'd5, 5'd19, 5'd30, 6'd63, 7'd0, "R1 reset fp");

    // R2: integer write does not touch the fp table
    do_write(0, 5'd5, 1, 0, 6'd40);
    look(3'b011, 3'b010, 5'd5, 5'd5, 5'd1, 6'd3, 7'd8, "R2 int vs fp");

    // R4: scalar redirect ignores offset, reaches upper half
    look(3'b001, 3'b000, 5'd5, 5'd2, 5'd3, 6'd17, 7'd8, "R4 scalar");

    // R5: vector wrap modulo 64
    do_write(1, 5'd9, 1, 1, 6'd60);
    look(3'b001, 3'b001, 5'd9, 5'd9, 5'd9, 6'd10, 7'd8, "R5 wrap");

    // R6: hit on an unused port is ignored
    look(3'b010, 3'b001, 5'd9, 5'd2, 5'd3, 6'd0, 7'd8, "R6 unused hit");

    // R7: zero length stops even with a hit
    look(3'b001, 3'b000, 5'd5, 5'd2, 5'd3, 6'd0, 7'd0, "R7 vl zero");

    // R8: lookup in the write cycle sees old entry, new one next cycle
    @(negedge clk);
    wr_en = 1; wr_fp = 0; wr_idx = 5'd12; wr_active = 1; wr_isvec = 1; wr_target = 6'd33;
    lk_use = 3'b001; lk_fp = 3'b000; lk_reg = {5'd0, 5'd0, 5'd12}; elem_offs = 6'd2; vec_len = 7'd5;
    #1 chk("R8 old value", 32'(phys_reg[5:0]), 32'd12);
    @(posedge clk); #1;
    wr_en = 0;
    m_act[0][12] = 1; m_vec[0][12] = 1; m_tgt[0][12] = 6'd33;
    @(negedge clk); #1;
    chk("R8 new value", 32'(phys_reg[5:0]), 32'd35);

    // deactivate: back to passthrough (R3)
    do_write(0, 5'd5, 0, 1, 6'd50);
    look(3'b111, 3'b000, 5'd5, 5'd12, 5'd5, 6'd9, 7'd3, "R3 deactivated");

    // random mix, writes overlapping lookups
    for (int it = 0; it < 3000; it++) begin
      bit we, wf, wa, wv; bit [4:0] wi; bit [5:0] wt;
      @(negedge clk);
      we = ($urandom % 3) == 0; wf = $urandom; wi = $urandom; wa = ($urandom % 4) != 0;
      wv = $urandom; wt = $urandom;
      wr_en = we; wr_fp = wf; wr_idx = wi; wr_active = wa; wr_isvec = wv; wr_target = wt;
      lk_use = $urandom; lk_fp = $urandom; lk_reg = $urandom;
      elem_offs = $urandom; vec_len = (($urandom % 5) == 0) ? '0 : VLW'($urandom);
      #1 check_all("R8 random");
      @(posedge clk); #1;
      if (we) begin m_act[wf][wi] = wa; m_vec[wf][wi] = wv; m_tgt[wf][wi] = wt; end
    end
    wr_en = 0;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule